// File: doc/BRIEF.md
# Programmable Two-Digit BCD Up-Counter

This block is a synchronous up-counter with a programmable stopping point between 0 and 99. Its value is shown as two binary-coded decimal digits, so it can drive a pair of decimal displays with no further conversion. One control input, `run`, selects between an idle phase and a counting phase. While idle, the count sits at zero and the block keeps sampling a 7-bit binary limit. While counting, the count starts from zero, climbs by one on every rising clock edge, and freezes once it equals the limit that was captured.

A limit above 99 is clamped to 99, so the displayed value never leaves the two-digit decimal range. The limit register is written only while idle. Moving the limit input during a count therefore changes neither the stopping point nor the running value. A shift-and-add-3 network converts the registered binary count to decimal. It is purely combinational, so the digits follow the count in the same cycle.

Top module: `bcd_limit_counter`

## Requirements
- R1: While `run` is 0, every rising clock edge forces the count to 0, and both digits read 0 after that edge.
- R2: While `run` is 0, the limit register loads `limit_in` on every rising edge, so the value present at the last edge before counting begins is the one used. A `limit_in` above 99 is stored as 99.
- R3: After `run` rises, the count advances by exactly one on each rising edge, starting from 0: k edges with `run` at 1 give a count of k, for as long as k does not exceed the captured limit.
- R4: Once the count equals the captured limit, it holds that value on every later edge for as long as `run` stays 1.
- R5: Changing `limit_in` while `run` is 1 affects neither the running count nor its stopping point.
- R6: A captured limit of 0 keeps the count at 0 after `run` rises.
- R7: `tens_digit` carries the decimal tens digit and `ones_digit` the decimal units digit of the count. Each is a 4-bit value from 0 to 9, and both change in the same cycle as the count.
- R8: An active-low `rst_n` asynchronously clears the count and the limit register to 0. With `run` held at 1 through and after reset, the count stays 0.
- R9: Lowering `run` in the middle of a count returns the count to 0 at the next edge and re-arms limit capture for the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 0 = idle and capture limit, 1 = count toward the limit |
| limit_in | input | 7 | Binary stopping value, clamped to 99 |
| ones_digit | output | 4 | Units BCD digit of the count |
| tens_digit | output | 4 | Tens BCD digit of the count |

## Verification
The properties assume that `run` and `limit_in` change only between clock edges and that reset is released away from an edge. The bench therefore drives every input on the falling clock edge and reads the digits one falling edge later, after exactly one rising edge has passed. The properties also assume that the count can never exceed the stored limit. This holds because the limit is rewritten only on edges that also clear the count. The stimulus tests that assumption by moving `limit_in` to a lower value in the middle of a run.

// File: rtl/bcdcnt_pkg.sv
`timescale 1ns/1ps
package bcdcnt_pkg;
  localparam int DEF_CNT_W   = 7;
  localparam int DEF_MAX_VAL = 99;
  localparam int BCD_DIGIT_W = 4;

  // Operating phase of the counter, derived for observation.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_HOLD  = 2'd2
  } cnt_phase_e;
endpackage

// File: rtl/bcdcnt_limit.sv
`timescale 1ns/1ps
module bcdcnt_limit #(
  parameter int CNT_W   = bcdcnt_pkg::DEF_CNT_W,
  parameter int MAX_VAL = bcdcnt_pkg::DEF_MAX_VAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic [CNT_W-1:0] raw_limit,
  output logic [CNT_W-1:0] limit_q
);
  localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_VAL);

  function automatic logic [CNT_W-1:0] clamp_limit(input logic [CNT_W-1:0] raw);
    return (raw > CEIL) ? CEIL : raw;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      limit_q <= '0;
    else if (capture_en)
      limit_q <= clamp_limit(raw_limit);
  end
endmodule

// File: rtl/bcdcnt_core.sv
`timescale 1ns/1ps
module bcdcnt_core #(
  parameter int CNT_W = bcdcnt_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit_q,
  output logic [CNT_W-1:0] count_q,
  output logic             at_limit,
  output logic             advance
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign at_limit = (count_q >= limit_q);
  assign advance  = run && !at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (!run)
      count_q <= '0;
    else if (advance)
      count_q <= bump(count_q);
  end
endmodule

// File: rtl/bcdcnt_bin2bcd.sv
`timescale 1ns/1ps
module bcdcnt_bin2bcd #(
  parameter int CNT_W  = bcdcnt_pkg::DEF_CNT_W,
  parameter int DIGITS = 2
) (
  input  logic [CNT_W-1:0]    bin,
  output logic [DIGITS*4-1:0] bcd
);
  localparam int BW = DIGITS * 4;

  // Shift-and-add-3: correct every digit of 5 or more, then shift one bit in, MSB first.
  function automatic logic [BW-1:0] dabble(input logic [CNT_W-1:0] v);
    logic [BW-1:0] acc;
    acc = '0;
    for (int i = CNT_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[d*4 +: 4] >= 4'd5)
          acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BW-2:0], v[i]};
    end
    return acc;
  endfunction

  assign bcd = dabble(bin);
endmodule

// File: rtl/bcd_limit_counter.sv
`timescale 1ns/1ps
module bcd_limit_counter #(
  parameter int CNT_W   = bcdcnt_pkg::DEF_CNT_W,
  parameter int MAX_VAL = bcdcnt_pkg::DEF_MAX_VAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit_in,
  output logic [3:0]       ones_digit,
  output logic [3:0]       tens_digit
);
  import bcdcnt_pkg::*;

  localparam int DIGITS = 2;

  logic             capture_en;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_q;
  logic             at_limit;
  logic             advance;
  logic [DIGITS*4-1:0] bcd;
  cnt_phase_e       phase;

  assign capture_en = !run;

  bcdcnt_limit #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL)) u_limit (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .raw_limit  (limit_in),
    .limit_q    (limit_q)
  );

  bcdcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .limit_q  (limit_q),
    .count_q  (count_q),
    .at_limit (at_limit),
    .advance  (advance)
  );

  bcdcnt_bin2bcd #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_conv (
    .bin (count_q),
    .bcd (bcd)
  );

  always_comb begin
    if (!run)          phase = PH_IDLE;
    else if (at_limit) phase = PH_HOLD;
    else               phase = PH_COUNT;
  end

  assign ones_digit = bcd[3:0];
  assign tens_digit = bcd[7:4];
endmodule

// File: rtl/bcdcnt_chk.sv
`timescale 1ns/1ps
module bcdcnt_chk #(
  parameter int CNT_W   = 7,
  parameter int MAX_VAL = 99
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] limit_q,
  input logic             advance,
  input logic [1:0]       phase,
  input logic [3:0]       ones_digit,
  input logic [3:0]       tens_digit
);
  // R1
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_q == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R4
  hold_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> $stable(count_q));

  // R5
  limit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(limit_q));

  // R2
  limit_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(limit_q) <= MAX_VAL);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit_q);

  // R7
  digit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_digit <= 4'd9) && (tens_digit <= 4'd9) &&
    (int'(tens_digit) * 10 + int'(ones_digit) == int'(count_q)));
endmodule

bind bcd_limit_counter bcdcnt_chk #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .count_q    (count_q),
  .limit_q    (limit_q),
  .advance    (advance),
  .phase      (phase),
  .ones_digit (ones_digit),
  .tens_digit (tens_digit)
);

// File: tb/sim_bcd_limit_counter.sv
`timescale 1ns/1ps
module sim_bcd_limit_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [6:0] limit_in = 7'd0;
  logic [3:0] ones_digit;
  logic [3:0] tens_digit;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bcd_limit_counter u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .limit_in   (limit_in),
    .ones_digit (ones_digit),
    .tens_digit (tens_digit)
  );

  function automatic int clamp99(input int v);
    return (v > 99) ? 99 : v;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check_out(input string req, input int expv);
    checks++;
    if (tens_digit !== 4'(expv / 10) || ones_digit !== 4'(expv % 10)) begin
      fails++;
      $display("FAIL %s: digits %0d%0d expected %0d%0d", req,
               tens_digit, ones_digit, expv / 10, expv % 10);
    end
  endtask

  // One idle edge with the given limit; returns at a falling edge with count 0.
  task automatic idle_load(input int lim);
    @(negedge clk);
    run = 1'b0;
    limit_in = 7'(lim);
    @(negedge clk);
    check_out("R1", 0);
  endtask

  // Assumes run was set to 1 at the current falling edge, k_first edges from start.
  task automatic run_span(input int lim_eff, input int k_first, input int n, input string req);
    for (int k = k_first; k < k_first + n; k++) begin
      @(negedge clk);
      check_out(req, min2(k, lim_eff));
    end
  endtask

  task automatic t_reset_state;
    repeat (2) @(negedge clk);
    check_out("R8", 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_stays_zero;
    idle_load(37);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_out("R1", 0);
    end
  endtask

  task automatic t_count_and_hold;
    idle_load(12);
    run = 1'b1;
    run_span(12, 1, 12, "R3");
    run_span(12, 13, 8, "R4");
  endtask

  task automatic t_limit_frozen;
    idle_load(73);
    run = 1'b1;
    run_span(73, 1, 10, "R3");
    limit_in = 7'd15;
    run_span(73, 11, 85, "R5");
  endtask

  task automatic t_saturate;
    idle_load(118);
    run = 1'b1;
    run_span(clamp99(118), 1, 106, "R2");
  endtask

  task automatic t_last_edge_wins;
    @(negedge clk);
    run = 1'b0;
    limit_in = 7'd60;
    @(negedge clk);
    limit_in = 7'd7;
    @(negedge clk);
    run = 1'b1;
    run_span(7, 1, 12, "R2");
  endtask

  task automatic t_zero_limit;
    idle_load(0);
    run = 1'b1;
    run_span(0, 1, 6, "R6");
  endtask

  task automatic t_abort_rearm;
    idle_load(40);
    run = 1'b1;
    run_span(40, 1, 20, "R3");
    run = 1'b0;
    limit_in = 7'd5;
    @(negedge clk);
    check_out("R9", 0);
    run = 1'b1;
    run_span(5, 1, 9, "R9");
  endtask

  task automatic t_all_digits;
    idle_load(99);
    run = 1'b1;
    run_span(99, 1, 100, "R7");
  endtask

  task automatic t_reset_midcount;
    idle_load(50);
    run = 1'b1;
    run_span(50, 1, 25, "R3");
    rst_n = 1'b0;
    #1;
    check_out("R8", 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_span(0, 1, 6, "R8");
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    run_span(50, 1, 8, "R9");
  endtask

  initial begin
    t_reset_state();
    t_idle_stays_zero();
    t_count_and_hold();
    t_limit_frozen();
    t_saturate();
    t_last_edge_wins();
    t_zero_limit();
    t_abort_rearm();
    t_all_digits();
    t_reset_midcount();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule